// File: doc/BRIEF.md
# Armed Interval Meter with Phase Unwrapping

This block measures the time, in reference clock ticks, from an edge on channel A to the next edge on channel B. A measurement opens only when an external arm pulse arrives, for example a once-per-second pulse. Both channels run at about the same period, so every raw interval lies within one period.

When the two signals differ slightly in frequency, the raw interval drifts slowly. Once per beat it jumps from near one full period to near zero, or from near zero to near one full period. The block detects each such jump and keeps a signed count of whole periods. Each result it outputs is the raw interval plus that count times the period. The output is therefore a continuous phase record and not a sawtooth, which is what a downstream stability estimator needs.

A clear input sets the period count to zero without losing the last raw interval. An arm pulse that arrives while a measurement is still open is ignored and sets a sticky overrun flag.

Top module: `phase_unwrap_meter`

## Requirements
- R1: After reset, `meas_valid_o`, `overrun_o`, `wraps_o`, `raw_o` and `meas_o` are all zero and no measurement is open.
- R2: A measurement opens only on an arm pulse seen while no measurement is open. Channel edges are ignored when no measurement is open. A B edge before the first A edge is ignored. An A edge in the same cycle as the arm pulse does not start the interval.
- R3: `raw_o` is the number of clock cycles from the A strobe to the B strobe. An A and a B strobe in the same cycle give 0.
- R4: `meas_valid_o` pulses for exactly one cycle, in the cycle after the B strobe that closes the measurement, once per armed measurement. Results update only with that pulse.
- R5: Each raw interval is compared with the previous one. If it rose by more than half of `period_i`, `wraps_o` decrements by one. If it fell by more than half, `wraps_o` increments by one. A change of exactly half a period leaves `wraps_o` unchanged.
- R6: The first measurement after reset has nothing to compare with and leaves `wraps_o` at zero.
- R7: `meas_o` is the signed value `raw_o + wraps_o * period_i`.
- R8: An arm pulse while a measurement is open has no effect on that measurement. It sets `overrun_o`, which stays set until reset.
- R9: `clear_i` sets `wraps_o` to zero and keeps `raw_o` and the previous raw interval, so the next measurement is still compared with it. If a clear arrives in the same cycle as a closing B strobe, the wrap step for that result is applied starting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the interval time base |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | One-cycle arm strobe that opens a measurement |
| edge_a_i | input | 1 | One-cycle strobe marking a channel A edge |
| edge_b_i | input | 1 | One-cycle strobe marking a channel B edge |
| clear_i | input | 1 | Sets the wrap count to zero |
| period_i | input | CW | Nominal channel period in ticks |
| meas_valid_o | output | 1 | One-cycle pulse when a new result is presented |
| raw_o | output | CW | Last raw A-to-B interval in ticks |
| wraps_o | output | AW | Signed count of whole periods added so far |
| meas_o | output | CW+AW+1 | Signed unwrapped interval |
| overrun_o | output | 1 | Sticky flag for an arm pulse during an open measurement |

## Verification
The assertions assume the following about the inputs:
- The strobes are synchronous one-cycle pulses.
- `clear_i` is low while reset is applied.
- Raw intervals never reach the counter limit.

The stimulus keeps within these assumptions:
- It drives every strobe for exactly one clock.
- It holds the period constant at 100 ticks.
- It keeps intervals below 100.

Within these limits it drives:
- both wrap directions;
- the exact half-period tie;
- coincident A and B strobes;
- stray and early edges;
- a second arm pulse inside a window;
- clears both alone and together with a closing B strobe.

// File: rtl/phase_unwrap_meter.sv
module phase_unwrap_meter #(
  parameter int CW = 16,
  parameter int AW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm_i,
  input  logic                 edge_a_i,
  input  logic                 edge_b_i,
  input  logic                 clear_i,
  input  logic [CW-1:0]        period_i,
  output logic                 meas_valid_o,
  output logic [CW-1:0]        raw_o,
  output logic signed [AW-1:0] wraps_o,
  output logic signed [CW+AW:0] meas_o,
  output logic                 overrun_o
);
  localparam int OW = CW + AW + 1;
  localparam int DW = CW + 3;

  typedef enum logic [1:0] {IDLE, WAIT_A, WAIT_B} state_t;

  state_t        state;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] prev_q;
  logic          have_q;

  wire done = ((state == WAIT_A) && edge_a_i && edge_b_i) ||
              ((state == WAIT_B) && edge_b_i);
  wire [CW-1:0] raw_now = (state == WAIT_B) ? cnt_q : '0;

  wire signed [DW-1:0] dbl = ($signed({3'b000, raw_now}) - $signed({3'b000, prev_q})) <<< 1;
  wire signed [DW-1:0] per = $signed({3'b000, period_i});
  wire jump_up = have_q && (dbl > per);
  wire jump_dn = have_q && (dbl < -per);

  wire signed [AW-1:0] wr_base = clear_i ? '0 : wraps_o;
  wire signed [AW-1:0] wr_next = jump_up ? wr_base - AW'(1) :
                                 jump_dn ? wr_base + AW'(1) : wr_base;

  wire signed [OW-1:0] wr_ext    = OW'(wr_next);
  wire signed [OW-1:0] per_ext   = $signed({{(OW-CW){1'b0}}, period_i});
  wire signed [OW-1:0] raw_ext   = $signed({{(OW-CW){1'b0}}, raw_now});
  wire signed [OW-1:0] meas_next = raw_ext + wr_ext * per_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= IDLE;
      cnt_q        <= '0;
      prev_q       <= '0;
      have_q       <= 1'b0;
      meas_valid_o <= 1'b0;
      raw_o        <= '0;
      wraps_o      <= '0;
      meas_o       <= '0;
      overrun_o    <= 1'b0;
    end else begin
      meas_valid_o <= done;
      if (arm_i && state != IDLE) overrun_o <= 1'b1;

      case (state)
        IDLE:   if (arm_i) state <= WAIT_A;
        WAIT_A: if (edge_a_i) begin
                  state <= edge_b_i ? IDLE : WAIT_B;
                  cnt_q <= CW'(1);
                end
        WAIT_B: if (edge_b_i) state <= IDLE;
                else cnt_q <= cnt_q + CW'(1);
        default: state <= IDLE;
      endcase

      if (done) begin
        raw_o   <= raw_now;
        prev_q  <= raw_now;
        have_q  <= 1'b1;
        wraps_o <= wr_next;
        meas_o  <= meas_next;
      end else if (clear_i) begin
        wraps_o <= '0;
      end
    end
  end
endmodule

// File: rtl/phase_unwrap_meter_chk.sv
module phase_unwrap_meter_chk #(
  parameter int CW = 16,
  parameter int AW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 arm_i,
  input logic                 edge_a_i,
  input logic                 edge_b_i,
  input logic                 clear_i,
  input logic [CW-1:0]        period_i,
  input logic                 meas_valid_o,
  input logic [CW-1:0]        raw_o,
  input logic signed [AW-1:0] wraps_o,
  input logic signed [CW+AW:0] meas_o,
  input logic                 overrun_o
);
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid_o |=> !meas_valid_o);

  p_valid_after_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid_o |-> $past(edge_b_i));

  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  p_wrap_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid_o && !$past(clear_i)) |->
      (wraps_o == $past(wraps_o) || wraps_o == $past(wraps_o) + AW'(1) ||
       wraps_o == $past(wraps_o) - AW'(1)));

  p_wraps_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_valid_o && !$past(clear_i)) |-> $stable(wraps_o));

  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clear_i) && !meas_valid_o) |-> (wraps_o == '0));

  p_raw_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid_o |-> ($stable(raw_o) && $stable(meas_o)));
endmodule

bind phase_unwrap_meter phase_unwrap_meter_chk #(.CW(CW), .AW(AW)) u_chk (.*);

// File: tb/test_phase_unwrap_meter.sv
module test_phase_unwrap_meter;
  localparam int CW = 16;
  localparam int AW = 12;
  localparam int P  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, ea = 1'b0, eb = 1'b0, clr = 1'b0;
  logic [CW-1:0] period = CW'(P);
  logic meas_valid, overrun;
  logic [CW-1:0] raw;
  logic signed [AW-1:0] wraps;
  logic signed [CW+AW:0] meas;

  phase_unwrap_meter #(.CW(CW), .AW(AW)) i_phase_unwrap_meter (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .edge_a_i(ea), .edge_b_i(eb),
    .clear_i(clr), .period_i(period), .meas_valid_o(meas_valid), .raw_o(raw),
    .wraps_o(wraps), .meas_o(meas), .overrun_o(overrun));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, nvalid = 0, npushed = 0;
  int m_prev = 0, m_acc = 0;
  bit m_have = 0;
  int q_raw[$], q_wr[$], q_meas[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_result(int r, bit c);
    if (c) m_acc = 0;
    if (m_have) begin
      if (2 * (r - m_prev) > P) m_acc--;
      else if (2 * (r - m_prev) < -P) m_acc++;
    end
    m_prev = r;
    m_have = 1;
    q_raw.push_back(r);
    q_wr.push_back(m_acc);
    q_meas.push_back(r + m_acc * P);
    npushed++;
  endtask

  task automatic run(int lead, int ival, bit clr_b, bit rearm, bit a_early, bit b_early);
    expect_result(ival, clr_b);
    @(negedge clk); arm = 1; ea = a_early;
    @(negedge clk); arm = 0; ea = 0;
    for (int i = 0; i < lead; i++) begin
      if (i == 0) begin arm = rearm; eb = b_early; end
      @(negedge clk); arm = 0; eb = 0;
    end
    ea = 1; eb = (ival == 0); clr = clr_b && (ival == 0);
    @(negedge clk); ea = 0; eb = 0; clr = 0;
    if (ival > 0) begin
      repeat (ival - 1) @(negedge clk);
      eb = 1; clr = clr_b;
      @(negedge clk); eb = 0; clr = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && meas_valid) begin
      nvalid++;
      if (q_raw.size() == 0) begin
        chk(0, "R2 unexpected result", int'(raw), -1);
      end else begin
        int er, ew, em;
        er = q_raw.pop_front(); ew = q_wr.pop_front(); em = q_meas.pop_front();
        chk(int'(raw) == er, "R3 raw interval", int'(raw), er);
        chk(int'(wraps) == ew, "R5 wrap count", int'(wraps), ew);
        chk(int'(meas) == em, "R7 unwrapped value", int'(meas), em);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(meas_valid == 0, "R1 valid", int'(meas_valid), 0);
    chk(overrun == 0, "R1 overrun", int'(overrun), 0);
    chk(wraps == 0, "R1 wraps", int'(wraps), 0);
    chk(raw == 0 && meas == 0, "R1 data", int'(raw), 0);

    // R2: edges with no arm pulse are ignored
    ea = 1; @(negedge clk); ea = 0; eb = 1; @(negedge clk); eb = 0;
    ea = 1; eb = 1; @(negedge clk); ea = 0; eb = 0;
    repeat (3) @(negedge clk);
    chk(nvalid == 0, "R2 idle edges", nvalid, 0);

    run(2, 10, 0, 0, 0, 0);   // R6 first result, no compare
    run(0, 40, 0, 0, 0, 0);
    run(1, 90, 0, 0, 0, 0);   // R5 rise of exactly half: no wrap
    run(0, 97, 0, 0, 0, 0);
    run(0, 3, 0, 0, 0, 0);    // R5 fall: +1
    run(0, 8, 0, 0, 0, 0);
    run(0, 0, 0, 0, 0, 0);    // R3 coincident strobes
    run(0, 96, 0, 0, 0, 0);   // R5 rise: back to 0
    run(0, 40, 0, 0, 0, 0);
    run(0, 90, 0, 0, 0, 0);
    run(0, 30, 0, 0, 0, 0);   // wraps = 2
    chk(int'(wraps) == 2, "R5 accumulated", int'(wraps), 2);

    // R9 standalone clear keeps raw
    clr = 1; @(negedge clk); clr = 0;
    chk(wraps == 0, "R9 clear wraps", int'(wraps), 0);
    chk(raw == 30, "R9 clear keeps raw", int'(raw), 30);
    m_acc = 0;
    run(0, 85, 0, 0, 0, 0);   // R9 previous raw still compared: -1
    run(0, 20, 1, 0, 0, 0);   // R9 clear with closing strobe: 0 then +1

    chk(overrun == 0, "R8 overrun before", int'(overrun), 0);
    run(3, 25, 0, 1, 0, 0);   // R8 second arm ignored
    chk(overrun == 1, "R8 overrun set", int'(overrun), 1);
    run(2, 22, 0, 0, 1, 0);   // R2 A with arm ignored
    run(2, 27, 0, 0, 0, 1);   // R2 early B ignored
    chk(overrun == 1, "R8 overrun sticky", int'(overrun), 1);

    repeat (4) @(negedge clk);
    chk(nvalid == npushed, "R4 one result per measurement", nvalid, npushed);
    chk(q_raw.size() == 0, "R4 pending results", q_raw.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule